// File: doc/BRIEF.md
# HDLC transmit frame queue controller

This block feeds a bit-serial HDLC transmitter from a queue of host-written bytes. Each queued byte carries two marks that the host sets with a separate control write. One mark says that the byte is the last of its frame. The other asks for the frame to be aborted after that byte. Several frames may wait in the queue at once, and frame boundaries come only from these marks, never from a length count.

The serializer asks for work with a request strobe. In the same cycle the controller answers with a command and a byte: idle fill, a data byte, a final data byte that the serializer must follow with CRC and a closing flag, or an abort sequence. If the serializer asks while a frame is open and the queue is empty, that is an underrun. The controller sends an abort, reports it, and holds the line in forced idle until the host reads the status.

A status word reports frame done, underrun abort and an illegal-tag error. A host read clears the first two. An interrupt line follows frame-done events when they are enabled. The idle fill is either continuous flags or all ones, picked by a control input. Deassertion of the asynchronous reset is synchronised inside the block, and a synchronous transmitter reset empties everything.

Top module: `hdlc_txq_ctrl`

## Requirements
- R1: After reset or a one-cycle `txrst`, `sts` is 0, `irq` is 0 and the queue is empty, so a request is answered with idle (`tx_cmd` 0).
- R2: Whenever `tx_cmd` is idle (0), `tx_data` is 8'h7E if `idle_flags` is 1 and 8'hFF if it is 0.
- R3: Queued bytes are handed out in write order, one per cycle with `tx_req` high. An untagged byte goes out as data (`tx_cmd` 1). A byte marked last goes out as final (`tx_cmd` 2), and in the next cycle `sts` bit 0 (done) is set.
- R4: A tag write applies to the byte written in the same cycle, or else to the newest queued byte. Once a byte is marked last, later tag writes do not change it.
- R5: An abort mark on a byte that is not the first of its frame: that byte is sent as data, and the next request is answered with abort (`tx_cmd` 3), which sets done but not underrun. An abort mark on the first byte of a frame is ignored: the byte goes out as data and the frame stays open.
- R6: A request in an open frame with an empty queue is answered with abort. In the next cycle `sts` is 3'b011 (done, underrun in bit 1). After that, requests get idle whatever the queue holds, until a status read. Queued bytes are kept.
- R7: A cycle with `sts_rd` high clears done and underrun in the next cycle. A done or underrun event in that same cycle still leaves its bit set.
- R8: `irq` rises in the cycle after a done event only if `done_ie` was 1 during that event. Raising `done_ie` later does not raise it. A status read clears it.
- R9: A tag write with both marks set sets `sts` bit 2 (error) in the next cycle. From then on requests get idle and no byte leaves the queue. A status read leaves the error set, and only `txrst` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| txrst | input | 1 | Synchronous transmitter reset |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Byte to queue |
| tag_wr | input | 1 | Tag write strobe |
| tag_done | input | 1 | Mark as last byte of frame |
| tag_abort | input | 1 | Mark for abort after this byte |
| idle_flags | input | 1 | Idle fill: 1 flags, 0 all ones |
| done_ie | input | 1 | Enable interrupt on frame done |
| sts_rd | input | 1 | Host read of the status word |
| tx_req | input | 1 | Serializer request; transfer happens in this cycle |
| tx_cmd | output | 2 | 0 idle, 1 data, 2 final data, 3 abort |
| tx_data | output | 8 | Byte for the command |
| sts | output | 3 | Bit 0 done, bit 1 underrun, bit 2 error |
| irq | output | 1 | Interrupt line |

## Verification
The collision that matters is a host status read landing in the same cycle as the transfer that ends a frame: the clear and the set then hit the same status bit and the interrupt line. The bench provokes this by raising `sts_rd` together with `tx_req` while a final byte is at the head of the queue. It passes only if done and `irq` are both set in the following cycle. A second pairing, a tag write in the same cycle as the byte's push, is exercised by marking single-byte frames as they are written.

// File: rtl/hdlc_txq_pkg.sv
package hdlc_txq_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
  localparam logic [BYTE_W-1:0] ONES_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_DATA  = 2'd1,
    CMD_LAST  = 2'd2,
    CMD_ABORT = 2'd3
  } tx_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_APEND,
    ST_FORCED,
    ST_ERROR
  } txq_state_e;

  typedef struct packed {
    logic              fin;
    logic              abt;
    logic [BYTE_W-1:0] data;
  } txq_entry_t;
endpackage

// File: rtl/hdlc_txq_fifo.sv
// Byte queue with per-entry tags; tags may be added to the newest entry.
// DEPTH must be a power of two.
module hdlc_txq_fifo
  import hdlc_txq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       push,
  input  txq_entry_t push_entry,
  input  logic       tag_wr,
  input  logic       tag_fin,
  input  logic       tag_abt,
  input  logic       pop,
  output txq_entry_t head,
  output logic       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  txq_entry_t    mem [DEPTH];
  logic [AW-1:0] wptr, rptr, tail;
  logic [CW-1:0] cnt;
  logic          full, do_push, do_pop, do_tag;

  assign full    = (cnt == FULL_CNT);
  assign empty   = (cnt == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign tail    = wptr - AW'(1);
  assign do_tag  = tag_wr & ~push & ~empty & ~mem[tail].fin;
  assign head    = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= wptr + AW'(1);
      if (do_pop)  rptr <= rptr + AW'(1);
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (!do_push && do_pop) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wptr] <= push_entry;
    end else if (do_tag) begin
      mem[tail].fin <= mem[tail].fin | tag_fin;
      mem[tail].abt <= mem[tail].abt | tag_abt;
    end
  end
endmodule

// File: rtl/hdlc_txq_fsm.sv
// Frame control: answers serializer requests, detects underrun and abort.
module hdlc_txq_fsm
  import hdlc_txq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tx_req,
  input  txq_entry_t        head,
  input  logic              empty,
  input  logic              sts_rd,
  input  logic              illegal,
  input  logic              idle_flags,
  output tx_cmd_e           cmd,
  output logic [BYTE_W-1:0] dat,
  output logic              pop,
  output logic              ev_done,
  output logic              ev_unde
);
  txq_state_e        st, nxt;
  logic [BYTE_W-1:0] idle_byte;

  assign idle_byte = idle_flags ? FLAG_BYTE : ONES_BYTE;

  always_comb begin
    nxt     = st;
    cmd     = CMD_IDLE;
    dat     = idle_byte;
    pop     = 1'b0;
    ev_done = 1'b0;
    ev_unde = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (!empty) begin
          dat = head.data;
          cmd = head.fin ? CMD_LAST : CMD_DATA;
          if (tx_req) begin
            pop     = 1'b1;
            ev_done = head.fin;
            nxt     = head.fin ? ST_IDLE : ST_FRAME;
          end
        end
      end
      ST_FRAME: begin
        if (!empty) begin
          dat = head.data;
          if (head.fin) begin
            cmd = CMD_LAST;
            if (tx_req) begin
              pop     = 1'b1;
              ev_done = 1'b1;
              nxt     = ST_IDLE;
            end
          end else begin
            cmd = CMD_DATA;
            if (tx_req) begin
              pop = 1'b1;
              if (head.abt) nxt = ST_APEND;
            end
          end
        end else begin
          cmd = CMD_ABORT;
          dat = '0;
          if (tx_req) begin
            ev_done = 1'b1;
            ev_unde = 1'b1;
            nxt     = ST_FORCED;
          end
        end
      end
      ST_APEND: begin
        cmd = CMD_ABORT;
        dat = '0;
        if (tx_req) begin
          ev_done = 1'b1;
          nxt     = ST_IDLE;
        end
      end
      ST_FORCED: begin
        if (sts_rd) nxt = ST_IDLE;
      end
      default: begin
      end
    endcase
    if (illegal) nxt = ST_ERROR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st <= ST_IDLE;
    else if (clr) st <= ST_IDLE;
    else          st <= nxt;
  end
endmodule

// File: rtl/hdlc_txq_status.sv
// Clear-on-read status word and interrupt line; a set beats a clear in the same cycle.
module hdlc_txq_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       ev_done,
  input  logic       ev_unde,
  input  logic       ev_err,
  input  logic       rd,
  input  logic       ie,
  output logic [2:0] sts,
  output logic       irq
);
  logic done_q, unde_q, err_q, irq_q;
  logic done_n, unde_n, err_n, irq_n;

  always_comb begin
    done_n = ev_done | (done_q & ~rd);
    unde_n = ev_unde | (unde_q & ~rd);
    err_n  = ev_err  | err_q;
    irq_n  = (ev_done & ie) | (irq_q & ~rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      unde_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else if (clr) begin
      done_q <= 1'b0;
      unde_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      unde_q <= unde_n;
      err_q  <= err_n;
      irq_q  <= irq_n;
    end
  end

  assign sts = {err_q, unde_q, done_q};
  assign irq = irq_q;
endmodule

// File: rtl/hdlc_txq_ctrl.sv
module hdlc_txq_ctrl
  import hdlc_txq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        txrst,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        tag_wr,
  input  logic        tag_done,
  input  logic        tag_abort,
  input  logic        idle_flags,
  input  logic        done_ie,
  input  logic        sts_rd,
  input  logic        tx_req,
  output logic [1:0]  tx_cmd,
  output logic [7:0]  tx_data,
  output logic [2:0]  sts,
  output logic        irq
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  txq_entry_t push_entry, head;
  logic       empty, pop, ev_done, ev_unde, illegal;
  tx_cmd_e    cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign illegal    = tag_wr & tag_done & tag_abort;
  assign push_entry = '{fin: tag_wr & tag_done, abt: tag_wr & tag_abort, data: wr_data};

  hdlc_txq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr        (txrst),
    .push       (wr_en),
    .push_entry (push_entry),
    .tag_wr     (tag_wr),
    .tag_fin    (tag_done),
    .tag_abt    (tag_abort),
    .pop        (pop),
    .head       (head),
    .empty      (empty)
  );

  hdlc_txq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr        (txrst),
    .tx_req     (tx_req),
    .head       (head),
    .empty      (empty),
    .sts_rd     (sts_rd),
    .illegal    (illegal),
    .idle_flags (idle_flags),
    .cmd        (cmd),
    .dat        (tx_data),
    .pop        (pop),
    .ev_done    (ev_done),
    .ev_unde    (ev_unde)
  );

  hdlc_txq_status u_sts (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (txrst),
    .ev_done (ev_done),
    .ev_unde (ev_unde),
    .ev_err  (illegal),
    .rd      (sts_rd),
    .ie      (done_ie),
    .sts     (sts),
    .irq     (irq)
  );

  assign tx_cmd = cmd;
endmodule

// File: rtl/hdlc_txq_ctrl_chk.sv
module hdlc_txq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txrst,
  input logic       idle_flags,
  input logic       done_ie,
  input logic       sts_rd,
  input logic       tx_req,
  input logic [1:0] tx_cmd,
  input logic [7:0] tx_data,
  input logic [2:0] sts,
  input logic       irq
);
  assert_idle_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cmd == 2'd0) |-> (tx_data == (idle_flags ? 8'h7E : 8'hFF)));

  assert_underrun_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[1]) |-> sts[0]);

  assert_forced_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sts[1] |-> (tx_cmd == 2'd0));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && !(tx_req && tx_cmd[1])) |=> !sts[0] && !sts[1]);

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(done_ie) && sts[0]));

  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[2] && !txrst) |=> sts[2]);

  assert_error_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sts[2] |-> (tx_cmd == 2'd0));
endmodule

bind hdlc_txq_ctrl hdlc_txq_ctrl_chk u_chk (.*);

// File: tb/hdlc_txq_ctrl_test.sv
module hdlc_txq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] C_IDLE = 2'd0, C_DATA = 2'd1, C_LAST = 2'd2, C_ABRT = 2'd3;

  logic clk = 1'b0;
  logic rst_n, txrst, wr_en, tag_wr, tag_done, tag_abort;
  logic idle_flags, done_ie, sts_rd, tx_req;
  logic [7:0] wr_data, tx_data;
  logic [1:0] tx_cmd;
  logic [2:0] sts;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_txq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .txrst(txrst), .wr_en(wr_en), .wr_data(wr_data),
    .tag_wr(tag_wr), .tag_done(tag_done), .tag_abort(tag_abort),
    .idle_flags(idle_flags), .done_ie(done_ie), .sts_rd(sts_rd), .tx_req(tx_req),
    .tx_cmd(tx_cmd), .tx_data(tx_data), .sts(sts), .irq(irq)
  );

  function automatic logic [7:0] idle_byte();
    return idle_flags ? 8'h7E : 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, input logic td, input logic ta);
    wr_en = 1; wr_data = d; tag_wr = td | ta; tag_done = td; tag_abort = ta;
    step();
    wr_en = 0; tag_wr = 0; tag_done = 0; tag_abort = 0;
  endtask

  task automatic tagw(input logic td, input logic ta);
    tag_wr = 1; tag_done = td; tag_abort = ta;
    step();
    tag_wr = 0; tag_done = 0; tag_abort = 0;
  endtask

  task automatic xfer(input string req, input logic [1:0] ecmd, input logic [7:0] edat);
    tx_req = 1;
    #1;
    chk({req, " cmd"}, tx_cmd, ecmd);
    if (ecmd != C_ABRT) chk({req, " data"}, tx_data, edat);
    step();
    tx_req = 0;
  endtask

  task automatic rd_status();
    sts_rd = 1;
    step();
    sts_rd = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset sts", sts, 3'b000);
    chk("R1 reset irq", irq, 1'b0);
    xfer("R1 reset empty", C_IDLE, 8'h7E);
  endtask

  task automatic t_idle_select();
    idle_flags = 0;
    xfer("R2 ones idle", C_IDLE, 8'hFF);
    idle_flags = 1;
    xfer("R2 flag idle", C_IDLE, 8'h7E);
  endtask

  task automatic t_normal_frame();
    push(8'hA0, 0, 0); push(8'hA1, 0, 0); push(8'hA2, 0, 0);
    tagw(1, 0);
    xfer("R3 byte0", C_DATA, 8'hA0);
    xfer("R3 byte1", C_DATA, 8'hA1);
    chk("R3 no done mid frame", sts, 3'b000);
    xfer("R3 last", C_LAST, 8'hA2);
    chk("R3 done", sts, 3'b001);
    chk("R8 irq on done", irq, 1'b1);
    xfer("R3 idle after frame", C_IDLE, 8'h7E);
    rd_status();
    chk("R7 read clears", sts, 3'b000);
    chk("R8 read clears irq", irq, 1'b0);
  endtask

  task automatic t_tag_target();
    push(8'h81, 0, 0); push(8'h82, 0, 0);
    tagw(1, 0);
    xfer("R4 older byte untagged", C_DATA, 8'h81);
    xfer("R4 newest tagged", C_LAST, 8'h82);
    rd_status();
  endtask

  task automatic t_tag_lock();
    push(8'h77, 0, 0);
    tagw(1, 0);
    tagw(0, 1);
    xfer("R4 locked last", C_LAST, 8'h77);
    xfer("R4 no abort after lock", C_IDLE, 8'h7E);
    chk("R4 status", sts, 3'b001);
    rd_status();
  endtask

  task automatic t_abort_tag();
    push(8'hC1, 0, 0); push(8'hC2, 0, 0);
    tagw(0, 1);
    xfer("R5 first", C_DATA, 8'hC1);
    xfer("R5 abort-tagged byte", C_DATA, 8'hC2);
    xfer("R5 abort seq", C_ABRT, 8'h00);
    chk("R5 done no underrun", sts, 3'b001);
    rd_status();
  endtask

  task automatic t_first_abort_ignored();
    push(8'hB1, 0, 1);
    push(8'hB2, 1, 0);
    xfer("R5 first-byte abort ignored", C_DATA, 8'hB1);
    xfer("R5 frame continues", C_LAST, 8'hB2);
    chk("R5 ended by close", sts, 3'b001);
    rd_status();
  endtask

  task automatic t_underrun();
    push(8'h11, 0, 0); push(8'h22, 0, 0);
    xfer("R6 d0", C_DATA, 8'h11);
    xfer("R6 d1", C_DATA, 8'h22);
    xfer("R6 underrun abort", C_ABRT, 8'h00);
    chk("R6 status", sts, 3'b011);
    chk("R6 irq", irq, 1'b1);
    push(8'h44, 0, 0);
    xfer("R6 forced idle", C_IDLE, 8'h7E);
    idle_flags = 0;
    xfer("R6 forced idle ones", C_IDLE, 8'hFF);
    idle_flags = 1;
    rd_status();
    chk("R7 clears underrun", sts, 3'b000);
    xfer("R6 byte kept", C_DATA, 8'h44);
    push(8'h55, 1, 0);
    xfer("R6 close", C_LAST, 8'h55);
    rd_status();
  endtask

  task automatic t_irq_mask();
    done_ie = 0;
    push(8'h90, 1, 0);
    xfer("R8 masked frame", C_LAST, 8'h90);
    chk("R8 done set", sts, 3'b001);
    chk("R8 no irq masked", irq, 1'b0);
    done_ie = 1;
    step();
    chk("R8 late enable no irq", irq, 1'b0);
    rd_status();
  endtask

  task automatic t_collision();
    push(8'h33, 1, 0);
    tx_req = 1; sts_rd = 1;
    #1;
    chk("R7 collide cmd", tx_cmd, C_LAST);
    step();
    tx_req = 0; sts_rd = 0;
    chk("R7 set wins over read", sts, 3'b001);
    chk("R8 irq set wins", irq, 1'b1);
    rd_status();
    chk("R7 later read clears", sts, 3'b000);
  endtask

  task automatic t_error();
    push(8'h66, 0, 0);
    tagw(1, 1);
    chk("R9 error set", sts, 3'b100);
    xfer("R9 no byte in error", C_IDLE, 8'h7E);
    rd_status();
    chk("R9 read keeps error", sts, 3'b100);
    txrst = 1;
    step();
    txrst = 0;
    chk("R1 txrst clears sts", sts, 3'b000);
    xfer("R1 txrst empties queue", C_IDLE, 8'h7E);
  endtask

  initial begin
    rst_n = 0; txrst = 0; wr_en = 0; wr_data = 0; tag_wr = 0; tag_done = 0;
    tag_abort = 0; idle_flags = 1; done_ie = 1; sts_rd = 0; tx_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_idle_select();
    t_normal_frame();
    t_tag_target();
    t_tag_lock();
    t_abort_tag();
    t_first_abort_ignored();
    t_underrun();
    t_irq_mask();
    t_collision();
    t_error();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule